// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block manages one bank of general-purpose pins behind a small synchronous register bus with a write strobe, a read strobe, a byte address and 32-bit data. Every pin is owned either by the bank's own GPIO logic or by one of two internal peripheral functions, called A and B. Under GPIO ownership, software controls the output enable, the output level, an open-drain drive mode, a pull-up and an input glitch filter. All of these are per-pin bits.

Every configuration bit changes only through a pair of addresses: one sets the bits written as 1, the other clears them. Each register also has its own read-only status address. The sampled pin level can always be read back. Any change of that level, rising or falling, latches an interrupt bit. Reading the latched bits clears them, and the bank interrupt line is raised when a latched bit is also unmasked. The pad side of the block gets a drive enable, a drive value and a pull-up enable for each pin.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is GPIO-owned (ownership status 0x08 reads all ones) and its pull-up is enabled (0x68 all ones, pad_pu all ones). Output enable (0x18), interrupt mask (0x48) and the irq output all read 0.
- R2: For each register, writing 1 to a bit at its set address sets that bit and writing 1 at its clear address clears it. Bits written as 0 keep their value. The pairs are: ownership 0x00/0x04, output enable 0x10/0x14, filter 0x20/0x24, output data 0x30/0x34, interrupt mask 0x40/0x44, open-drain 0x50/0x54, pull-up 0x64/0x60.
- R3: The output data (status 0x38) can be set while the output enable is off. Once the output enable is on, a GPIO pin drives pad_oe=1 with pad_out equal to the stored level.
- R4: Writing 1 to a bit at 0x04 hands that pin to a peripheral, and ownership status then reads 0 for it. Address 0x74 routes the pin to peripheral B and 0x70 routes it to peripheral A, with status 0x78 reading 1 for B. The pad then follows the chosen peripheral's output and output enable.
- R5: Pin data status (0x3C) returns the pin level after a two-flop synchronizer, whatever owns the pin. It therefore shows a pad change two clock edges later.
- R6: A rising or a falling change of the sampled level sets that pin's bit in interrupt status (0x4C). A read of 0x4C returns the latched bits and clears them.
- R7: irq is high exactly when some interrupt status bit is set and the same mask bit is set.
- R8: When open-drain is enabled and the pin's output level is 1, the pin is not driven (pad_oe=0). When the level is 0, it drives low.
- R9: With the filter enabled, a pin accepts a new level only after the synchronized input has held it for two consecutive clocks. A one-clock pulse changes neither the data status nor the interrupt status.
- R10: If a change is detected in the same cycle that interrupt status is read, the new bit stays latched after the read clears the older bits.
- R11: pad_pu follows the pull-up register, which is cleared at 0x60 and set at 0x64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears interrupt status on 0x4C) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, bit n is pin n |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad drive value |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pad pull-up enable |
| per_a_out | input | 32 | Peripheral A output value |
| per_a_oe | input | 32 | Peripheral A output enable |
| per_b_out | input | 32 | Peripheral B output value |
| per_b_oe | input | 32 | Peripheral B output enable |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is a level change that is detected in exactly the cycle an interrupt-status read clears the register. The change reaches the detector two clock edges after the pad moves. So the bench changes the pad on a falling edge, waits two more falling edges, and only then raises the read strobe while an older bit is still pending. It then expects the read to return only the old bit and the next read to return only the new one. The glitch filter is reached in a similar way, with pulses that are exactly one and exactly several clocks wide, and both the data status and the interrupt status are checked afterwards.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;

   localparam int OWN_SET  = 'h00, OWN_CLR  = 'h04, OWN_STS  = 'h08;
   localparam int OE_SET   = 'h10, OE_CLR   = 'h14, OE_STS   = 'h18;
   localparam int FLT_SET  = 'h20, FLT_CLR  = 'h24, FLT_STS  = 'h28;
   localparam int DAT_SET  = 'h30, DAT_CLR  = 'h34, DAT_STS  = 'h38;
   localparam int PIN_STS  = 'h3C;
   localparam int MSK_SET  = 'h40, MSK_CLR  = 'h44, MSK_STS  = 'h48;
   localparam int ISR_RD   = 'h4C;
   localparam int OD_SET   = 'h50, OD_CLR   = 'h54, OD_STS   = 'h58;
   localparam int PU_CLR   = 'h60, PU_SET   = 'h64, PU_STS   = 'h68;
   localparam int SELA     = 'h70, SELB     = 'h74, SEL_STS  = 'h78;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int W       = 32,
   parameter int AW      = 8,
   parameter int SET_OFF = 0,
   parameter int CLR_OFF = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  q
);
   localparam logic [AW-1:0] SET_A = SET_OFF[AW-1:0];
   localparam logic [AW-1:0] CLR_A = CLR_OFF[AW-1:0];

   logic hit_set, hit_clr;
   assign hit_set = wr && (addr == SET_A);
   assign hit_clr = wr && (addr == CLR_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST_VAL;
      else if (hit_set) q <= q | wdata;
      else if (hit_clr) q <= q & ~wdata;
   end

   // R2: written ones take effect, written zeros keep the old value
   p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> ((q & $past(wdata)) == $past(wdata)));
   p_clr_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> ((q & $past(wdata)) == '0));
   p_zero_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_set || hit_clr) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
   parameter int N           = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pad_in,
   input  logic [N-1:0] flt_en,
   output logic [N-1:0] level,
   output logic [N-1:0] change
);
   logic [N-1:0] sync_q [SYNC_STAGES];
   logic [N-1:0] sync_v;
   logic [N-1:0] flt_q, pend_q, prev_q;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else if (s == 0) sync_q[s] <= pad_in;
            else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_v = sync_q[SYNC_STAGES-1];

   generate
      for (genvar p = 0; p < N; p++) begin : g_flt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flt_q[p]  <= 1'b0;
               pend_q[p] <= 1'b0;
            end else if (!flt_en[p] || sync_v[p] == flt_q[p]) begin
               flt_q[p]  <= sync_v[p];
               pend_q[p] <= 1'b0;
            end else if (pend_q[p]) begin
               flt_q[p]  <= sync_v[p];
               pend_q[p] <= 1'b0;
            end else begin
               pend_q[p] <= 1'b1;
            end
         end

         // R9: a filtered level moves only to a value held on the previous sample
         p_flt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_en[p] && $past(flt_en[p]) && flt_q[p] != $past(flt_q[p]))
               |-> ($past(sync_v[p]) == flt_q[p]));
      end
   endgenerate

   assign level = (flt_en & flt_q) | (~flt_en & sync_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign change = level ^ prev_q;
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] change,
   input  logic         rd_clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] isr,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      isr <= '0;
      else if (rd_clr) isr <= change;
      else             isr <= isr | change;
   end

   assign irq = |(isr & mask);

   // R10: a change seen in the read cycle survives the clear
   p_edge_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (change != '0) |=> ((isr & $past(change)) == $past(change)));
   // R6: a read with no new change empties the status
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && change == '0) |=> (isr == '0));
   // R7: the line is only raised by an unmasked latched bit
   p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (isr != '0 && mask != '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   input  logic [NUM_PINS-1:0] per_a_out,
   input  logic [NUM_PINS-1:0] per_a_oe,
   input  logic [NUM_PINS-1:0] per_b_out,
   input  logic [NUM_PINS-1:0] per_b_oe,
   output logic              irq
);
   localparam int N = NUM_PINS;
   localparam logic [N-1:0] ONES = '1;

   generate
      if (N < 1 || N > DATA_W) begin : g_bad_width
         $error("NUM_PINS must be between 1 and the bus data width");
      end
   endgenerate

   logic [N-1:0] wd;
   assign wd = bus_wdata[N-1:0];

   logic [N-1:0] own_q, oe_q, flt_q, dat_q, msk_q, od_q, pu_q, selb_q;
   logic [N-1:0] level, change, isr;
   logic         isr_rd;

   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(OWN_SET), .CLR_OFF(OWN_CLR), .RST_VAL(ONES))
      u_own (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(own_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(OE_SET), .CLR_OFF(OE_CLR), .RST_VAL('0))
      u_oe (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(oe_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(FLT_SET), .CLR_OFF(FLT_CLR), .RST_VAL('0))
      u_flt (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(flt_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(DAT_SET), .CLR_OFF(DAT_CLR), .RST_VAL('0))
      u_dat (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(dat_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(MSK_SET), .CLR_OFF(MSK_CLR), .RST_VAL('0))
      u_msk (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(msk_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(OD_SET), .CLR_OFF(OD_CLR), .RST_VAL('0))
      u_od (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(od_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(PU_SET), .CLR_OFF(PU_CLR), .RST_VAL(ONES))
      u_pu (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(pu_q));
   gpio_setclr_reg #(.W(N), .AW(ADDR_W), .SET_OFF(SELB), .CLR_OFF(SELA), .RST_VAL('0))
      u_sel (.clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(wd), .q(selb_q));

   gpio_in_path #(.N(N), .SYNC_STAGES(SYNC_STAGES))
      u_in (.clk, .rst_n, .pad_in, .flt_en(flt_q), .level, .change);

   assign isr_rd = bus_rd && (bus_addr == ISR_RD[ADDR_W-1:0]);

   gpio_irq_latch #(.N(N))
      u_irq (.clk, .rst_n, .change, .rd_clr(isr_rd), .mask(msk_q), .isr, .irq);

   // pad drive: GPIO or selected peripheral, then the open-drain gate
   generate
      for (genvar p = 0; p < N; p++) begin : g_pad
         logic drv_v, drv_e;
         always_comb begin
            if (own_q[p]) begin
               drv_v = dat_q[p];
               drv_e = oe_q[p];
            end else if (selb_q[p]) begin
               drv_v = per_b_out[p];
               drv_e = per_b_oe[p];
            end else begin
               drv_v = per_a_out[p];
               drv_e = per_a_oe[p];
            end
         end
         assign pad_out[p] = drv_v & ~od_q[p];
         assign pad_oe[p]  = drv_e & ~(od_q[p] & drv_v);
      end
   endgenerate

   assign pad_pu = pu_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OWN_STS[ADDR_W-1:0]: bus_rdata[N-1:0] = own_q;
         OE_STS[ADDR_W-1:0]:  bus_rdata[N-1:0] = oe_q;
         FLT_STS[ADDR_W-1:0]: bus_rdata[N-1:0] = flt_q;
         DAT_STS[ADDR_W-1:0]: bus_rdata[N-1:0] = dat_q;
         PIN_STS[ADDR_W-1:0]: bus_rdata[N-1:0] = level;
         MSK_STS[ADDR_W-1:0]: bus_rdata[N-1:0] = msk_q;
         ISR_RD[ADDR_W-1:0]:  bus_rdata[N-1:0] = isr;
         OD_STS[ADDR_W-1:0]:  bus_rdata[N-1:0] = od_q;
         PU_STS[ADDR_W-1:0]:  bus_rdata[N-1:0] = pu_q;
         SEL_STS[ADDR_W-1:0]: bus_rdata[N-1:0] = selb_q;
         default:             bus_rdata = '0;
      endcase
   end

   // R8: an open-drain pin never actively drives a high level
   p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((od_q & pad_oe & pad_out) == '0));
   // R11: the pad pull-up follows the register at every edge
   p_pu_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == PU_CLR[ADDR_W-1:0]) |=> ((pad_pu & $past(wd)) == '0));
endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pad_pu;
   logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
   logic        irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_bank_ctrl i_gpio_bank_ctrl (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(8'h08, v); chk("R1 own", v, 32'hFFFF_FFFF);
      rd(8'h68, v); chk("R1 pu", v, 32'hFFFF_FFFF);
      rd(8'h18, v); chk("R1 oe", v, 32'h0);
      rd(8'h48, v); chk("R1 mask", v, 32'h0);
      chk("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_setclr;
      logic [31:0] v;
      wr(8'h10, 32'h0000_00F0);
      wr(8'h10, 32'h0000_0F00);
      rd(8'h18, v); chk("R2 set keeps", v, 32'h0000_0FF0);
      wr(8'h14, 32'h0000_0030);
      rd(8'h18, v); chk("R2 clear", v, 32'h0000_0FC0);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h18, v); chk("R2 clear all", v, 32'h0);
   endtask

   task automatic t_outdata;
      logic [31:0] v;
      wr(8'h30, 32'h20);
      chk("R3 no drive before oe", {31'b0, pad_oe[5]}, 32'h0);
      rd(8'h38, v); chk("R3 data sts", v, 32'h20);
      wr(8'h10, 32'h20);
      chk("R3 oe on", {31'b0, pad_oe[5]}, 32'h1);
      chk("R3 level high", {31'b0, pad_out[5]}, 32'h1);
      wr(8'h34, 32'h20);
      chk("R3 level low", {31'b0, pad_out[5]}, 32'h0);
   endtask

   task automatic t_pinlevel;
      logic [31:0] v;
      @(negedge clk); pad_in[6] = 1;
      @(negedge clk);
      #1 bus_addr = 8'h3C;
      #0.5 chk("R5 one edge", bus_rdata & 32'h40, 32'h0);
      @(negedge clk);
      #1 chk("R5 two edges", bus_rdata & 32'h40, 32'h40);
      rd(8'h4C, v);
      chk("R6 rise latched", v, 32'h40);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      @(negedge clk); pad_in[0] = 1;
      idle(4);
      chk("R7 masked", {31'b0, irq}, 32'h0);
      rd(8'h4C, v); chk("R6 rise", v, 32'h1);
      rd(8'h4C, v); chk("R6 cleared", v, 32'h0);
      @(negedge clk); pad_in[0] = 0;
      idle(4);
      wr(8'h40, 32'h1);
      chk("R7 unmasked", {31'b0, irq}, 32'h1);
      rd(8'h4C, v); chk("R6 fall", v, 32'h1);
      chk("R7 after clear", {31'b0, irq}, 32'h0);
      wr(8'h44, 32'h1);
   endtask

   task automatic t_race;
      logic [31:0] v;
      @(negedge clk); pad_in[0] = 1;
      idle(4);
      @(negedge clk); pad_in[1] = 1;
      @(negedge clk);
      @(negedge clk);
      bus_rd = 1; bus_addr = 8'h4C;
      #1 v = bus_rdata;
      @(negedge clk); bus_rd = 0;
      chk("R10 old bit read", v, 32'h1);
      rd(8'h4C, v); chk("R10 new bit kept", v, 32'h2);
   endtask

   task automatic t_filter;
      logic [31:0] v;
      wr(8'h20, 32'h4);
      idle(2);
      @(negedge clk); pad_in[2] = 1;
      @(negedge clk); pad_in[2] = 0;
      idle(5);
      rd(8'h3C, v); chk("R9 pulse data", v & 32'h4, 32'h0);
      rd(8'h4C, v); chk("R9 pulse irq", v, 32'h0);
      @(negedge clk); pad_in[2] = 1;
      idle(6);
      rd(8'h3C, v); chk("R9 stable data", v & 32'h4, 32'h4);
      rd(8'h4C, v); chk("R9 stable irq", v, 32'h4);
   endtask

   task automatic t_opendrain;
      wr(8'h10, 32'h8);
      wr(8'h50, 32'h8);
      wr(8'h30, 32'h8);
      chk("R8 release high", {31'b0, pad_oe[3]}, 32'h0);
      wr(8'h34, 32'h8);
      chk("R8 drive low oe", {31'b0, pad_oe[3]}, 32'h1);
      chk("R8 drive low val", {31'b0, pad_out[3]}, 32'h0);
   endtask

   task automatic t_periph;
      logic [31:0] v;
      per_a_out[4] = 1; per_a_oe[4] = 1; per_b_out[4] = 0; per_b_oe[4] = 1;
      wr(8'h04, 32'h10);
      rd(8'h08, v); chk("R4 own sts", v, 32'hFFFF_FFEF);
      chk("R4 A drive", {30'b0, pad_oe[4], pad_out[4]}, 32'h3);
      wr(8'h74, 32'h10);
      rd(8'h78, v); chk("R4 sel B", v, 32'h10);
      chk("R4 B drive", {30'b0, pad_oe[4], pad_out[4]}, 32'h2);
      wr(8'h70, 32'h10);
      rd(8'h78, v); chk("R4 sel A", v, 32'h0);
      @(negedge clk); pad_in[4] = 1;
      idle(3);
      rd(8'h3C, v); chk("R5 periph pin level", v & 32'h10, 32'h10);
   endtask

   task automatic t_pullup;
      logic [31:0] v;
      wr(8'h60, 32'h80);
      chk("R11 pad off", pad_pu, 32'hFFFF_FF7F);
      rd(8'h68, v); chk("R11 sts", v, 32'hFFFF_FF7F);
      wr(8'h64, 32'h80);
      chk("R11 pad on", pad_pu, 32'hFFFF_FFFF);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      t_reset;
      t_setclr;
      t_outdata;
      t_pinlevel;
      t_irq;
      t_race;
      t_filter;
      t_opendrain;
      t_periph;
      t_pullup;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule